// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block runs the core side of one coprocessor instruction at a time. Five kinds are supported: moving a value from the coprocessor into a core result register, moving a core value to the coprocessor, a pure coprocessor data operation, and a load or store between memory and the coprocessor. When started, the sequencer checks that the selected coprocessor may be used. It then offers the instruction and busy-waits for as long as the coprocessor answers busy. Each busy answer costs one idle cycle, and the offer is repeated with a busy phase code.

A pending interrupt, resolved by a fixed priority over reset, fast and normal requests, abandons the instruction during busy-wait. A refusal ("can't") ends it with an undefined-instruction trap for register and data operations, or with an abort for loads and stores. Loads and stores are post-indexed. The first word uses the given address, and each "increment" answer advances the address by 4 until the coprocessor answers "last". The block reports completion with a one-cycle `done` pulse, a status code, the interrupt source, a base-writeback flag, and per-cycle idle and coprocessor-cycle strobes.

Top module: `cphs_seq`

## Requirements
- R1: A start whose coprocessor number (instr bits 11:8) is not set in `cp_allow`, or whose `op` is not 0 to 4 (0 from-coprocessor, 1 to-coprocessor, 2 data operation, 3 load, 4 store), ends with status 1 (undefined) and `done` in the cycle after the start, without any offer (`cp_phase` stays 0).
- R2: The first offer has `cp_phase` 1 (first). After every busy answer (`cp_resp` 1), the next cycle is an idle cycle (`idle_cyc` high) that re-offers with `cp_phase` 2 (busy).
- R3: If an interrupt is taken during a busy re-offer, that cycle shows `cp_phase` 3 (interrupt), and the next cycle ends the instruction with status 3.
- R4: Interrupt priority is reset request first (`int_vec` 0), then fast request if `f_mask` is low (1), then normal request if `i_mask` is low (2). Masked requests are not taken.
- R5: A "can't" answer (`cp_resp` 2) ends register and data operations with status 1, and loads and stores with status 2 (abort).
- R6: A load or store transfers words at the given address, then the address plus 4 after each "increment" answer (`cp_resp` 3), and stops after the word answered "last" (`cp_resp` 0). A load passes `mem_rdata` to `cp_wdata`. A store passes `cp_rdata` to `mem_wdata`. A word moves only in a cycle with `mem_ready` high (`cp_phase` 4, data).
- R7: A load or store whose address has any bit at or above position 26 set, or a store to an address below 0x20, ends with status 2 and makes no offer.
- R8: `base_wb` is high with `done` when a load or store completes with status 0 and instr bit 21 is set, and is low otherwise.
- R9: After acceptance, a from-coprocessor transfer spends one coprocessor cycle (`cop_cyc`) and then one idle cycle before `done`. A to-coprocessor transfer spends one coprocessor cycle. Other operations spend none.
- R10: `result` takes `cp_rdata` when a from-coprocessor transfer is accepted, and is left unchanged otherwise, including on refusal.
- R11: A start while the block is busy is ignored, and each instruction produces exactly one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | begin an instruction (taken only when idle) |
| op | input | 3 | operation kind |
| instr | input | 32 | instruction word (bits 11:8 coprocessor, bit 21 writeback) |
| base_addr | input | 32 | first word address for loads and stores |
| src_data | input | 32 | value sent on a to-coprocessor transfer |
| cp_allow | input | 16 | per-coprocessor access permission |
| cp_resp | input | 2 | coprocessor answer: 0 last, 1 busy, 2 can't, 3 increment |
| cp_rdata | input | 32 | data from the coprocessor |
| cp_phase | output | 3 | phase code: 0 none, 1 first, 2 busy, 3 interrupt, 4 data |
| cp_wdata | output | 32 | data to the coprocessor |
| reset_req | input | 1 | pending reset request |
| fiq_req | input | 1 | pending fast interrupt |
| irq_req | input | 1 | pending normal interrupt |
| f_mask | input | 1 | fast interrupt mask |
| i_mask | input | 1 | normal interrupt mask |
| mem_req | output | 1 | memory access active |
| mem_we | output | 1 | memory write (store) |
| mem_addr | output | 32 | word address |
| mem_wdata | output | 32 | store data |
| mem_rdata | input | 32 | load data |
| mem_ready | input | 1 | memory completes the word this cycle |
| busy | output | 1 | instruction in progress |
| done | output | 1 | one-cycle completion pulse |
| status | output | 2 | 0 ok, 1 undefined, 2 abort, 3 interrupted |
| int_vec | output | 2 | interrupt source when status is 3 |
| base_wb | output | 1 | base writeback request |
| result | output | 32 | value received from the coprocessor |
| idle_cyc | output | 1 | idle cycle strobe |
| cop_cyc | output | 1 | coprocessor cycle strobe |

## Verification
On every cycle, the assertions check the following: the cycle after a busy answer is idle, an interrupt phase is followed at once by an interrupted completion, the address advances by exactly 4 after each increment answer, `result` changes only after an accepting answer, a refused coprocessor number completes in one cycle, and `done` never lasts two cycles. The bench scenarios are needed for the rest, because those facts only show up over a whole instruction. They include the interrupt priority and masking outcome, the abort-versus-undefined choice, the address-range and vector checks, the exact number of idle and coprocessor cycles, the word count and data routing under random memory stalls, and base writeback.

// File: rtl/cphs_pkg.sv
package cphs_pkg;
  localparam logic [2:0] OP_FROM  = 3'd0;
  localparam logic [2:0] OP_TO    = 3'd1;
  localparam logic [2:0] OP_DATA  = 3'd2;
  localparam logic [2:0] OP_LOAD  = 3'd3;
  localparam logic [2:0] OP_STORE = 3'd4;

  localparam logic [1:0] RSP_LAST = 2'd0;
  localparam logic [1:0] RSP_BUSY = 2'd1;
  localparam logic [1:0] RSP_CANT = 2'd2;
  localparam logic [1:0] RSP_INC  = 2'd3;

  localparam logic [2:0] PH_NONE  = 3'd0;
  localparam logic [2:0] PH_FIRST = 3'd1;
  localparam logic [2:0] PH_BUSY  = 3'd2;
  localparam logic [2:0] PH_INTR  = 3'd3;
  localparam logic [2:0] PH_DATA  = 3'd4;

  localparam logic [1:0] ST_OK    = 2'd0;
  localparam logic [1:0] ST_UNDEF = 2'd1;
  localparam logic [1:0] ST_ABORT = 2'd2;
  localparam logic [1:0] ST_INTR  = 2'd3;

  localparam logic [1:0] VEC_RESET = 2'd0;
  localparam logic [1:0] VEC_FAST  = 2'd1;
  localparam logic [1:0] VEC_NORM  = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_OFFER, S_WAIT, S_XFER, S_TAIL_C, S_TAIL_I, S_FIN
  } seq_state_e;
endpackage

// File: rtl/cphs_int_pri.sv
module cphs_int_pri
  import cphs_pkg::*;
(
  input  logic       reset_req,
  input  logic       fiq_req,
  input  logic       irq_req,
  input  logic       f_mask,
  input  logic       i_mask,
  output logic       take,
  output logic [1:0] vec
);
  always_comb begin
    take = 1'b1;
    vec  = VEC_RESET;
    if (reset_req) begin
      vec = VEC_RESET;
    end else if (fiq_req && !f_mask) begin
      vec = VEC_FAST;
    end else if (irq_req && !i_mask) begin
      vec = VEC_NORM;
    end else begin
      take = 1'b0;
    end
  end
endmodule

// File: rtl/cphs_addr_gen.sv
module cphs_addr_gen #(
  parameter int AW         = 32,
  parameter int LEGAL_BITS = 26,
  parameter int VEC_LIMIT  = 32,
  parameter int STEP       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] start_addr,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          start_exc,
  output logic          start_vec
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);
  localparam logic [AW-1:0] VEC_V  = AW'(VEC_LIMIT);

  generate
    if (LEGAL_BITS >= AW) begin : g_noexc
      assign start_exc = 1'b0;
    end else begin : g_exc
      assign start_exc = |start_addr[AW-1:LEGAL_BITS];
    end
  endgenerate

  assign start_vec = start_addr < VEC_V;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (load) begin
      addr <= start_addr;
    end else if (step) begin
      addr <= addr + STEP_V;
    end
  end
endmodule

// File: rtl/cphs_seq.sv
module cphs_seq
  import cphs_pkg::*;
#(
  parameter int DW         = 32,
  parameter int AW         = 32,
  parameter int NCP        = 16,
  parameter int CPN_LSB    = 8,
  parameter int WB_BIT     = 21,
  parameter int LEGAL_BITS = 26,
  parameter int VEC_LIMIT  = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [2:0]     op,
  input  logic [31:0]    instr,
  input  logic [AW-1:0]  base_addr,
  input  logic [DW-1:0]  src_data,
  input  logic [NCP-1:0] cp_allow,
  input  logic [1:0]     cp_resp,
  input  logic [DW-1:0]  cp_rdata,
  output logic [2:0]     cp_phase,
  output logic [DW-1:0]  cp_wdata,
  input  logic           reset_req,
  input  logic           fiq_req,
  input  logic           irq_req,
  input  logic           f_mask,
  input  logic           i_mask,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ready,
  output logic           busy,
  output logic           done,
  output logic [1:0]     status,
  output logic [1:0]     int_vec,
  output logic           base_wb,
  output logic [DW-1:0]  result,
  output logic           idle_cyc,
  output logic           cop_cyc
);
  localparam int CPN_W = $clog2(NCP);

  seq_state_e      state;
  logic [2:0]      op_q;
  logic            wb_q;
  logic [DW-1:0]   src_q;
  logic [1:0]      status_q;
  logic [1:0]      vec_q;
  logic            bwb_q;
  logic [DW-1:0]   result_q;

  logic            int_take;
  logic [1:0]      int_sel;
  logic            addr_load;
  logic            addr_step;
  logic            start_exc;
  logic            start_vec;
  logic [CPN_W-1:0] cpn;
  logic            is_ls;
  logic            accept;
  logic            take_start;

  cphs_int_pri u_pri (
    .reset_req (reset_req),
    .fiq_req   (fiq_req),
    .irq_req   (irq_req),
    .f_mask    (f_mask),
    .i_mask    (i_mask),
    .take      (int_take),
    .vec       (int_sel)
  );

  cphs_addr_gen #(
    .AW(AW), .LEGAL_BITS(LEGAL_BITS), .VEC_LIMIT(VEC_LIMIT), .STEP(4)
  ) u_addr (
    .clk        (clk),
    .rst        (rst),
    .load       (addr_load),
    .start_addr (base_addr),
    .step       (addr_step),
    .addr       (mem_addr),
    .start_exc  (start_exc),
    .start_vec  (start_vec)
  );

  assign cpn        = instr[CPN_LSB +: CPN_W];
  assign take_start = start && (state == S_IDLE);
  assign addr_load  = take_start;
  assign is_ls      = (op_q == OP_LOAD) || (op_q == OP_STORE);
  assign accept     = (cp_resp == RSP_LAST) || (cp_resp == RSP_INC);
  assign addr_step  = (state == S_XFER) && mem_ready && (cp_resp == RSP_INC);

  always_comb begin
    case (state)
      S_OFFER: cp_phase = PH_FIRST;
      S_WAIT:  cp_phase = int_take ? PH_INTR : PH_BUSY;
      S_XFER:  cp_phase = mem_ready ? PH_DATA : PH_NONE;
      default: cp_phase = PH_NONE;
    endcase
  end

  assign cp_wdata  = (state == S_XFER) ? mem_rdata : src_q;
  assign mem_req   = (state == S_XFER);
  assign mem_we    = (state == S_XFER) && (op_q == OP_STORE);
  assign mem_wdata = cp_rdata;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);
  assign status    = status_q;
  assign int_vec   = vec_q;
  assign base_wb   = bwb_q;
  assign result    = result_q;
  assign idle_cyc  = (state == S_WAIT) || (state == S_TAIL_I);
  assign cop_cyc   = (state == S_TAIL_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      op_q     <= OP_FROM;
      wb_q     <= 1'b0;
      src_q    <= '0;
      status_q <= ST_OK;
      vec_q    <= VEC_RESET;
      bwb_q    <= 1'b0;
      result_q <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            op_q     <= op;
            wb_q     <= instr[WB_BIT];
            src_q    <= src_data;
            status_q <= ST_OK;
            bwb_q    <= 1'b0;
            if ((op > OP_STORE) || !cp_allow[cpn]) begin
              status_q <= ST_UNDEF;
              state    <= S_FIN;
            end else if (((op == OP_LOAD) || (op == OP_STORE)) &&
                         (start_exc || ((op == OP_STORE) && start_vec))) begin
              status_q <= ST_ABORT;
              state    <= S_FIN;
            end else begin
              state <= S_OFFER;
            end
          end
        end
        S_OFFER, S_WAIT: begin
          if ((state == S_WAIT) && int_take) begin
            status_q <= ST_INTR;
            vec_q    <= int_sel;
            state    <= S_FIN;
          end else if (cp_resp == RSP_BUSY) begin
            state <= S_WAIT;
          end else if (cp_resp == RSP_CANT) begin
            status_q <= is_ls ? ST_ABORT : ST_UNDEF;
            state    <= S_FIN;
          end else begin
            case (op_q)
              OP_FROM: begin
                result_q <= cp_rdata;
                state    <= S_TAIL_C;
              end
              OP_TO:   state <= S_TAIL_C;
              OP_DATA: state <= S_FIN;
              default: state <= S_XFER;
            endcase
          end
        end
        S_XFER: begin
          if (mem_ready && (cp_resp != RSP_INC)) begin
            bwb_q <= wb_q;
            state <= S_FIN;
          end
        end
        S_TAIL_C: state <= (op_q == OP_FROM) ? S_TAIL_I : S_FIN;
        S_TAIL_I: state <= S_FIN;
        default:  state <= S_IDLE;
      endcase
    end
  end

  AST_BUSY_IDLE: assert property (@(posedge clk) disable iff (rst)
    ((cp_phase == PH_FIRST || cp_phase == PH_BUSY) && cp_resp == RSP_BUSY)
      |=> (idle_cyc && cp_phase != PH_FIRST)) else $error("busy answer not followed by idle re-offer"); // R2
  AST_INTR_ENDS: assert property (@(posedge clk) disable iff (rst)
    (cp_phase == PH_INTR) |=> (done && status == ST_INTR)) else $error("interrupt phase did not end instruction"); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(cp_phase == PH_DATA && cp_resp == RSP_INC))
      |-> (mem_addr == $past(mem_addr) + AW'(4))) else $error("address not advanced by 4"); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> $past((cp_phase == PH_FIRST || cp_phase == PH_BUSY) && accept)) else $error("result changed without acceptance"); // R10
  AST_DENY_FAST: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !cp_allow[cpn]) |=> (done && status == ST_UNDEF)) else $error("denied start not trapped"); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R11
endmodule

// File: tb/tb_cphs_seq.sv
`timescale 1ns/100ps
module tb_cphs_seq;
  localparam logic [31:0] RK = 32'h5A5A_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] instr = '0;
  logic [31:0] base_addr = '0;
  logic [31:0] src_data = '0;
  logic [15:0] cp_allow = '1;
  logic [1:0]  cp_resp;
  logic [31:0] cp_rdata = '0;
  logic [2:0]  cp_phase;
  logic [31:0] cp_wdata;
  logic        reset_req = 0, fiq_req = 0, irq_req = 0, f_mask = 0, i_mask = 0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready = 1'b1;
  logic        busy, done, base_wb, idle_cyc, cop_cyc;
  logic [1:0]  status, int_vec;
  logic [31:0] result;

  int checks = 0, errors = 0;
  int cfg_busy = 0, cfg_words = 1;
  logic [1:0] cfg_final = 2'd0;
  int bc = 0, wc = 0;
  bit running = 0;
  int n_idle = 0, n_cop = 0, n_words = 0;
  bit chk_ld = 0, chk_st = 0;
  logic [31:0] exp_base = '0;
  logic [31:0] exp_result = '0;

  always #2 clk = ~clk;

  cphs_seq dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .instr(instr),
    .base_addr(base_addr), .src_data(src_data), .cp_allow(cp_allow),
    .cp_resp(cp_resp), .cp_rdata(cp_rdata), .cp_phase(cp_phase),
    .cp_wdata(cp_wdata), .reset_req(reset_req), .fiq_req(fiq_req),
    .irq_req(irq_req), .f_mask(f_mask), .i_mask(i_mask),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .busy(busy), .done(done), .status(status), .int_vec(int_vec),
    .base_wb(base_wb), .result(result), .idle_cyc(idle_cyc), .cop_cyc(cop_cyc)
  );

  assign mem_rdata = mem_addr ^ RK;

  always_comb begin
    if (cp_phase == 3'd1 || cp_phase == 3'd2)
      cp_resp = (bc < cfg_busy) ? 2'd1 : cfg_final;
    else if (cp_phase == 3'd4)
      cp_resp = (wc < cfg_words - 1) ? 2'd3 : 2'd0;
    else
      cp_resp = 2'd0;
  end

  always @(posedge clk) begin
    if (start && !busy) begin
      bc <= 0;
      wc <= 0;
    end else begin
      if (cp_phase == 3'd1 || cp_phase == 3'd2) bc <= bc + 1;
      if (cp_phase == 3'd4) wc <= wc + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: cycle strobes and per-word data routing (R6, R9)
  always begin
    @(negedge clk);
    #0.8;
    if (running) begin
      if (idle_cyc) n_idle++;
      if (cop_cyc) n_cop++;
      if (cp_phase == 3'd4) begin
        check(mem_addr == exp_base + 32'(4 * n_words), "R6", "word address",
              mem_addr, exp_base + 32'(4 * n_words));
        if (chk_ld) check(cp_wdata == (mem_addr ^ RK), "R6", "load data",
                          cp_wdata, mem_addr ^ RK);
        if (chk_st) check(mem_wdata == cp_rdata && mem_we, "R6", "store data",
                          mem_wdata, cp_rdata);
        n_words++;
      end
    end
  end

  always @(negedge clk) mem_ready <= (($urandom % 4) != 0);

  function automatic logic [1:0] exp_status(input logic [2:0] o, input bit perm,
      input logic [31:0] a, input int nb, input logic [1:0] fin, input bit it);
    bit ls = (o == 3'd3) || (o == 3'd4);
    if (o > 3'd4 || !perm) return 2'd1;
    if (ls && ((|a[31:26]) || (o == 3'd4 && a < 32'h20))) return 2'd2;
    if (nb > 0 && it) return 2'd3;
    if (fin == 2'd2) return ls ? 2'd2 : 2'd1;
    return 2'd0;
  endfunction

  task automatic run_op(input logic [2:0] o, input logic [31:0] ins,
      input logic [31:0] a, input int nb, input logic [1:0] fin, input int nw,
      input bit poke);
    bit perm = cp_allow[ins[11:8]];
    bit it = reset_req || (fiq_req && !f_mask) || (irq_req && !i_mask);
    logic [1:0] es = exp_status(o, perm, a, nb, fin, it);
    logic [1:0] ev = reset_req ? 2'd0 : ((fiq_req && !f_mask) ? 2'd1 : 2'd2);
    bit ls = (o == 3'd3) || (o == 3'd4);
    bit pre = (o > 3'd4) || !perm ||
              (ls && ((|a[31:26]) || (o == 3'd4 && a < 32'h20)));
    int ei, ec, ew, lat, extra;
    logic [31:0] cpd = $urandom;
    if (pre) ei = 0;
    else if (es == 2'd3) ei = 1;
    else ei = nb + ((es == 2'd0 && o == 3'd0) ? 1 : 0);
    ec = (es == 2'd0 && (o == 3'd0 || o == 3'd1)) ? 1 : 0;
    ew = (es == 2'd0 && ls) ? nw : 0;
    @(negedge clk);
    cfg_busy = nb; cfg_final = fin; cfg_words = nw; cp_rdata = cpd;
    op = o; instr = ins; base_addr = a; src_data = $urandom;
    exp_base = a; chk_ld = (o == 3'd3); chk_st = (o == 3'd4);
    n_idle = 0; n_cop = 0; n_words = 0; running = 1;
    start = 1'b1;
    @(negedge clk);
    #0.4;
    start = 1'b0;
    check(cp_wdata == src_data || pre || ls, "R9", "to-cp source data", cp_wdata, src_data);
    lat = 1;
    while (!done && lat < 400) begin
      @(negedge clk);
      #0.4;
      lat++;
      if (poke && lat == 3) begin
        op = 3'd6; start = 1'b1;   // R11: start while busy must be ignored
      end else begin
        start = 1'b0;
      end
    end
    running = 0;
    check(done == 1'b1, "R11", "done seen", 32'(done), 1);
    if (pre && es == 2'd1) check(lat == 1, "R1", "trap latency", lat, 1);
    check(status == es, (es == 2'd1 && pre) ? "R1" : ((es == 2'd2 && pre) ? "R7" :
          ((es == 2'd3) ? "R3" : "R5")), "status", 32'(status), 32'(es));
    if (pre) check(n_idle == 0 && n_words == 0, "R1", "no offer on early trap", n_idle, 0);
    if (es == 2'd3) check(int_vec == ev, "R4", "interrupt source", 32'(int_vec), 32'(ev));
    check(n_idle == ei, "R2", "idle cycles", n_idle, ei);
    check(n_cop == ec, "R9", "coprocessor cycles", n_cop, ec);
    check(n_words == ew, "R6", "word count", n_words, ew);
    check(base_wb == (es == 2'd0 && ls && ins[21]), "R8", "base writeback",
          32'(base_wb), 32'(es == 2'd0 && ls && ins[21]));
    if (es == 2'd0 && o == 3'd0) exp_result = cpd;
    check(result == exp_result, "R10", "result register", result, exp_result);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #0.4;
      check(!done && !busy, "R11", "single done pulse", 32'(done), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #0.4;
    rst = 1'b0;
    check(!busy && !done && cp_phase == 3'd0 && !mem_req && result == 0,
          "R1", "reset state", result, 0);
    // R1 denied coprocessor
    cp_allow = 16'hFFFF & ~16'h0020;
    run_op(3'd0, 32'h0000_0500, 32'h100, 0, 2'd0, 1, 0);
    cp_allow = 16'hFFFF;
    run_op(3'd7, 32'h0000_0100, 32'h100, 0, 2'd0, 1, 0);          // R1 bad op
    run_op(3'd0, 32'h0000_0300, 32'h100, 2, 2'd0, 1, 0);          // R2 R9 R10
    run_op(3'd0, 32'h0000_0300, 32'h100, 1, 2'd2, 1, 0);          // R5 R10 refusal
    run_op(3'd1, 32'h0000_0300, 32'h100, 0, 2'd0, 1, 0);          // R9
    run_op(3'd3, 32'h0020_0200, 32'h400, 1, 2'd0, 4, 0);          // R6 R8
    run_op(3'd4, 32'h0020_0200, 32'h800, 0, 2'd0, 3, 0);          // R6 R8
    run_op(3'd4, 32'h0000_0200, 32'h10, 0, 2'd0, 1, 0);           // R7 vector store
    run_op(3'd3, 32'h0000_0200, 32'h10, 0, 2'd0, 1, 0);           // R7 vector load ok
    run_op(3'd3, 32'h0000_0200, 32'h0400_0000, 0, 2'd0, 1, 0);    // R7 range
    run_op(3'd4, 32'h0020_0200, 32'h900, 2, 2'd2, 1, 0);          // R5 abort
    reset_req = 1; fiq_req = 1; irq_req = 1;
    run_op(3'd2, 32'h0000_0100, 32'h0, 2, 2'd0, 1, 0);            // R4 reset first
    reset_req = 0;
    run_op(3'd2, 32'h0000_0100, 32'h0, 2, 2'd0, 1, 0);            // R4 fast
    f_mask = 1;
    run_op(3'd2, 32'h0000_0100, 32'h0, 2, 2'd0, 1, 0);            // R4 normal
    i_mask = 1;
    run_op(3'd2, 32'h0000_0100, 32'h0, 2, 2'd0, 1, 0);            // R4 both masked
    fiq_req = 0; irq_req = 0; f_mask = 0; i_mask = 0;
    run_op(3'd0, 32'h0000_0100, 32'h0, 5, 2'd0, 1, 1);            // R11 poke
    for (int n = 0; n < 60; n++) begin
      logic [2:0]  ro = 3'($urandom % 6);
      logic [31:0] ri = $urandom & 32'h0020_0F00;
      logic [31:0] ra;
      int pick = $urandom % 8;
      cp_allow = (($urandom % 5) == 0) ? 16'($urandom) : 16'hFFFF;
      ra = (pick == 0) ? 32'h0800_0040 : ((pick == 1) ? 32'h8 : 32'h1000 + (($urandom % 64) * 4));
      irq_req = (($urandom % 4) == 0);
      i_mask = (($urandom % 3) == 0);
      run_op(ro, ri, ra, $urandom % 4, (($urandom % 5) == 0) ? 2'd2 : 2'd0,
             1 + ($urandom % 4), 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule